// File: doc/BRIEF.md
# Trap Return State Update Unit

This unit carries out the two trap-return instructions of a processor core: the return from supervisor mode and the return from machine mode. The pipeline presents a one-cycle request with the instruction kind, the current privilege level and virtualization flag, the machine and hypervisor status words, and both saved exception PCs. Three configuration flags are also part of the request: compressed instructions, the hypervisor feature, and whether any memory-protection rule is configured.

The unit first runs the legality checks for the selected instruction in a fixed priority order. If a check fails, it reports the first failing check as an exception cause and leaves the architectural state as it was. If every check passes, it produces the following, all registered together one cycle after the request with a single-cycle done pulse:

- the rewritten status words;
- the privilege level and virtualization mode to return to;
- the return target PC.

The registered results stay on the outputs until the next request. Status-word fields keep their usual bit positions, because neighbouring logic decodes them.

Top module: `trap_return_unit`

## Requirements
- R1: A supervisor return requested at user privilege (encoding 0) reports an exception with cause 2 (illegal instruction).
- R2: When the compressed flag is 0 and the low two bits of the selected return PC are not both zero, the request reports cause 0 (misaligned target). When the compressed flag is 1, the same PC is accepted.
- R3: A supervisor return at supervisor privilege (encoding 1) with the trap-return-trap bit (machine status bit 22) set reports cause 2. At machine privilege (encoding 3) that bit has no effect.
- R4: A supervisor return has its own trap bit, hypervisor status bit 22. When that bit is set, the hypervisor flag is 1 and the virtualization flag is 1, the return reports cause 22 (virtual instruction). With the virtualization flag at 0 the bit has no effect.
- R5: A legal supervisor return makes these changes to the machine status word, and leaves every other bit unchanged:
  - bit 1 takes the value of bit 5;
  - bit 5 is set to 1;
  - bit 8 is cleared.
  The new privilege is the old value of bit 8 (0 selects user, 1 selects supervisor).
- R6: On a legal supervisor return with the hypervisor flag at 1 and the virtualization flag at 0, hypervisor status bit 7 is cleared and the new virtualization flag is the old value of that bit. In every other case the hypervisor word and the virtualization flag are unchanged.
- R7: A machine return requested below machine privilege reports cause 2.
- R8: A machine return reports cause 2 when no protection rule is configured and machine status bits 12:11 are not 3. With those bits equal to 3 it is legal.
- R9: A legal machine return makes these changes to the machine status word, and leaves every other bit and the hypervisor word unchanged:
  - bit 3 takes the value of bit 7;
  - bit 7 is set to 1;
  - bits 12:11 are cleared;
  - bit 39 is cleared.
  The new privilege is the old value of bits 12:11.
- R10: On a legal machine return the new virtualization flag is the old machine status bit 39 when the hypervisor flag is 1, and the current flag otherwise.
- R11: Only the first failing check is reported. The supervisor return checks privilege, then alignment, then machine bit 22, then hypervisor bit 22. The machine return checks privilege, then alignment, then protection presence.
- R12: On an exception, the following outputs equal the request's inputs: both status words, the privilege and the virtualization flag. In all cases the target PC is the saved PC of the mode being returned from.
- R13: Every result and a one-cycle done pulse appear one clock after the request, and the results hold while no request is present. After reset the outputs read: done 0, exception 0, privilege 3, virtualization 0, both status words 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | One-cycle return request |
| req_is_mret_i | input | 1 | 1 = machine return, 0 = supervisor return |
| cur_priv_i | input | 2 | Current privilege level |
| cur_virt_i | input | 1 | Current virtualization flag |
| mstatus_i | input | 64 | Machine status word |
| hstatus_i | input | 64 | Hypervisor status word |
| sepc_i | input | PC_W | Saved supervisor exception PC |
| mepc_i | input | PC_W | Saved machine exception PC |
| has_compressed_i | input | 1 | Compressed instructions supported |
| has_hyper_i | input | 1 | Hypervisor feature present |
| has_pmp_i | input | 1 | At least one protection rule configured |
| done_o | output | 1 | Result valid pulse |
| exc_valid_o | output | 1 | The request raised an exception |
| exc_cause_o | output | 5 | Exception cause code |
| mstatus_o | output | 64 | Updated machine status word |
| hstatus_o | output | 64 | Updated hypervisor status word |
| priv_o | output | 2 | New privilege level |
| virt_o | output | 1 | New virtualization flag |
| target_pc_o | output | PC_W | Return target PC |

## Verification
Every output passes through exactly one register, so all results of a request are due at the first rising edge after the cycle in which the request is high, and they then hold. The bench drives each request on a falling edge and drops it on the next falling edge. That falling edge lies half a period after the capturing edge, and it is where the bench compares all outputs, so no comparison races the clock. Separate tests then confirm four things: the done pulse falls one cycle later, the outputs do not follow changed inputs while idle, back-to-back requests each produce their own result in consecutive cycles, and the reset values are correct.

// File: rtl/trapret_pkg.sv
package trapret_pkg;

    localparam int STATUS_W = 64;
    localparam int CAUSE_W  = 5;

    // machine status field positions (decoded by neighbouring logic)
    localparam int MS_SIE  = 1;
    localparam int MS_MIE  = 3;
    localparam int MS_SPIE = 5;
    localparam int MS_MPIE = 7;
    localparam int MS_SPP  = 8;
    localparam int MS_MPP_LO = 11;
    localparam int MS_MPP_HI = 12;
    localparam int MS_TSR  = 22;
    localparam int MS_MPV  = 39;

    // hypervisor status field positions
    localparam int HS_SPV  = 7;
    localparam int HS_VTSR = 22;

    typedef enum logic [1:0] {
        PRIV_USER  = 2'd0,
        PRIV_SUPER = 2'd1,
        PRIV_MACH  = 2'd3
    } priv_e;

    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_MISALIGN = 5'd0,
        CAUSE_ILLEGAL  = 5'd2,
        CAUSE_VIRT     = 5'd22
    } cause_e;

endpackage

// File: rtl/trapret_legality.sv
module trapret_legality
    import trapret_pkg::*;
#(
    parameter int PC_W = 64
) (
    input  logic                is_mret_i,
    input  logic [1:0]          priv_i,
    input  logic                virt_i,
    input  logic [STATUS_W-1:0] mstatus_i,
    input  logic [STATUS_W-1:0] hstatus_i,
    input  logic [PC_W-1:0]     ret_pc_i,
    input  logic                has_c_i,
    input  logic                has_h_i,
    input  logic                has_pmp_i,
    output logic                fault_o,
    output logic [CAUSE_W-1:0]  cause_o
);

    logic misaligned;
    logic [1:0] mpp_old;

    assign misaligned = !has_c_i && (ret_pc_i[1:0] != 2'b00);
    assign mpp_old    = mstatus_i[MS_MPP_HI:MS_MPP_LO];

    // first failing check wins
    always_comb begin
        fault_o = 1'b0;
        cause_o = CAUSE_ILLEGAL;
        if (is_mret_i) begin
            if (priv_i != PRIV_MACH) begin
                fault_o = 1'b1;
                cause_o = CAUSE_ILLEGAL;
            end else if (misaligned) begin
                fault_o = 1'b1;
                cause_o = CAUSE_MISALIGN;
            end else if (!has_pmp_i && (mpp_old != PRIV_MACH)) begin
                fault_o = 1'b1;
                cause_o = CAUSE_ILLEGAL;
            end
        end else begin
            if (priv_i == PRIV_USER) begin
                fault_o = 1'b1;
                cause_o = CAUSE_ILLEGAL;
            end else if (misaligned) begin
                fault_o = 1'b1;
                cause_o = CAUSE_MISALIGN;
            end else if (mstatus_i[MS_TSR] && (priv_i != PRIV_MACH)) begin
                fault_o = 1'b1;
                cause_o = CAUSE_ILLEGAL;
            end else if (has_h_i && virt_i && hstatus_i[HS_VTSR]) begin
                fault_o = 1'b1;
                cause_o = CAUSE_VIRT;
            end
        end
    end

endmodule

// File: rtl/trapret_status_next.sv
module trapret_status_next
    import trapret_pkg::*;
(
    input  logic                is_mret_i,
    input  logic                virt_i,
    input  logic [STATUS_W-1:0] mstatus_i,
    input  logic [STATUS_W-1:0] hstatus_i,
    input  logic                has_h_i,
    output logic [STATUS_W-1:0] mstatus_o,
    output logic [STATUS_W-1:0] hstatus_o,
    output logic [1:0]          priv_o,
    output logic                virt_o
);

    always_comb begin
        mstatus_o = mstatus_i;
        hstatus_o = hstatus_i;
        virt_o    = virt_i;
        if (is_mret_i) begin
            priv_o                         = mstatus_i[MS_MPP_HI:MS_MPP_LO];
            mstatus_o[MS_MIE]              = mstatus_i[MS_MPIE];
            mstatus_o[MS_MPIE]             = 1'b1;
            mstatus_o[MS_MPP_HI:MS_MPP_LO] = 2'b00;
            mstatus_o[MS_MPV]              = 1'b0;
            if (has_h_i) begin
                virt_o = mstatus_i[MS_MPV];
            end
        end else begin
            priv_o             = {1'b0, mstatus_i[MS_SPP]};
            mstatus_o[MS_SIE]  = mstatus_i[MS_SPIE];
            mstatus_o[MS_SPIE] = 1'b1;
            mstatus_o[MS_SPP]  = 1'b0;
            if (has_h_i && !virt_i) begin
                hstatus_o[HS_SPV] = 1'b0;
                virt_o            = hstatus_i[HS_SPV];
            end
        end
    end

endmodule

// File: rtl/trap_return_unit.sv
module trap_return_unit
    import trapret_pkg::*;
#(
    parameter int PC_W = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid_i,
    input  logic                req_is_mret_i,
    input  logic [1:0]          cur_priv_i,
    input  logic                cur_virt_i,
    input  logic [STATUS_W-1:0] mstatus_i,
    input  logic [STATUS_W-1:0] hstatus_i,
    input  logic [PC_W-1:0]     sepc_i,
    input  logic [PC_W-1:0]     mepc_i,
    input  logic                has_compressed_i,
    input  logic                has_hyper_i,
    input  logic                has_pmp_i,
    output logic                done_o,
    output logic                exc_valid_o,
    output logic [CAUSE_W-1:0]  exc_cause_o,
    output logic [STATUS_W-1:0] mstatus_o,
    output logic [STATUS_W-1:0] hstatus_o,
    output logic [1:0]          priv_o,
    output logic                virt_o,
    output logic [PC_W-1:0]     target_pc_o
);

    typedef struct packed {
        logic                done;
        logic                exc;
        logic [CAUSE_W-1:0]  cause;
        logic [STATUS_W-1:0] ms;
        logic [STATUS_W-1:0] hs;
        logic [1:0]          priv;
        logic                virt;
        logic [PC_W-1:0]     pc;
    } result_t;

    result_t res_d, res_q;

    logic [PC_W-1:0]     ret_pc;
    logic                fault;
    logic [CAUSE_W-1:0]  cause;
    logic [STATUS_W-1:0] ms_new, hs_new;
    logic [1:0]          priv_new;
    logic                virt_new;

    assign ret_pc = req_is_mret_i ? mepc_i : sepc_i;

    trapret_legality #(.PC_W(PC_W)) legality_i (
        .is_mret_i (req_is_mret_i),
        .priv_i    (cur_priv_i),
        .virt_i    (cur_virt_i),
        .mstatus_i (mstatus_i),
        .hstatus_i (hstatus_i),
        .ret_pc_i  (ret_pc),
        .has_c_i   (has_compressed_i),
        .has_h_i   (has_hyper_i),
        .has_pmp_i (has_pmp_i),
        .fault_o   (fault),
        .cause_o   (cause)
    );

    trapret_status_next status_next_i (
        .is_mret_i (req_is_mret_i),
        .virt_i    (cur_virt_i),
        .mstatus_i (mstatus_i),
        .hstatus_i (hstatus_i),
        .has_h_i   (has_hyper_i),
        .mstatus_o (ms_new),
        .hstatus_o (hs_new),
        .priv_o    (priv_new),
        .virt_o    (virt_new)
    );

    always_comb begin
        res_d      = res_q;
        res_d.done = req_valid_i;
        if (req_valid_i) begin
            res_d.pc    = ret_pc;
            res_d.exc   = fault;
            res_d.cause = fault ? cause : '0;
            if (fault) begin
                res_d.ms   = mstatus_i;
                res_d.hs   = hstatus_i;
                res_d.priv = cur_priv_i;
                res_d.virt = cur_virt_i;
            end else begin
                res_d.ms   = ms_new;
                res_d.hs   = hs_new;
                res_d.priv = priv_new;
                res_d.virt = virt_new;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q      <= '0;
            res_q.priv <= PRIV_MACH;
        end else begin
            res_q <= res_d;
        end
    end

    assign done_o      = res_q.done;
    assign exc_valid_o = res_q.exc;
    assign exc_cause_o = res_q.cause;
    assign mstatus_o   = res_q.ms;
    assign hstatus_o   = res_q.hs;
    assign priv_o      = res_q.priv;
    assign virt_o      = res_q.virt;
    assign target_pc_o = res_q.pc;

    AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i |=> done_o); // R13
    AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |=> !done_o); // R13
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |=> ($stable(mstatus_o) && $stable(priv_o) && $stable(virt_o))); // R13
    AST_SRET_USER_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !req_is_mret_i && cur_priv_i == PRIV_USER)
        |=> (exc_valid_o && exc_cause_o == CAUSE_ILLEGAL)); // R1
    AST_MRET_LOW_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_is_mret_i && cur_priv_i != PRIV_MACH)
        |=> (exc_valid_o && exc_cause_o == CAUSE_ILLEGAL)); // R7
    AST_FAULT_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i |=> (!exc_valid_o ||
            (mstatus_o == $past(mstatus_i) && hstatus_o == $past(hstatus_i) &&
             priv_o == $past(cur_priv_i) && virt_o == $past(cur_virt_i)))); // R12
    AST_MRET_CLEARS_MPP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_is_mret_i) |=> (exc_valid_o ||
            (mstatus_o[MS_MPP_HI:MS_MPP_LO] == 2'b00 && mstatus_o[MS_MPIE] &&
             !mstatus_o[MS_MPV]))); // R9
    AST_SRET_SETS_SPIE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !req_is_mret_i) |=> (exc_valid_o ||
            (mstatus_o[MS_SPIE] && !mstatus_o[MS_SPP]))); // R5

endmodule

// File: tb/trap_return_unit_tb.sv
module trap_return_unit_tb_top;

    localparam int NV = 16;

    typedef struct packed {
        logic        mret;
        logic [1:0]  pr;
        logic        vi;
        logic [63:0] ms;
        logic [63:0] hs;
        logic [63:0] ep;
        logic [2:0]  cfg;   // {compressed, hyper, pmp}
        logic        x_exc;
        logic [4:0]  x_cause;
        logic [63:0] x_ms;
        logic [63:0] x_hs;
        logic [1:0]  x_pr;
        logic        x_vi;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd1, 1'b0, 64'h120,    64'h0,      64'h1000, 3'b101, 1'b0, 5'd0,  64'h22,     64'h0,      2'd1, 1'b0},
        '{1'b0, 2'd3, 1'b0, 64'h400002, 64'h0,      64'h1000, 3'b101, 1'b0, 5'd0,  64'h400020, 64'h0,      2'd0, 1'b0},
        '{1'b0, 2'd0, 1'b0, 64'h120,    64'h0,      64'h1000, 3'b101, 1'b1, 5'd2,  64'h120,    64'h0,      2'd0, 1'b0},
        '{1'b0, 2'd1, 1'b0, 64'h400120, 64'h0,      64'h1000, 3'b101, 1'b1, 5'd2,  64'h400120, 64'h0,      2'd1, 1'b0},
        '{1'b0, 2'd1, 1'b1, 64'h20,     64'h400000, 64'h1000, 3'b111, 1'b1, 5'd22, 64'h20,     64'h400000, 2'd1, 1'b1},
        '{1'b0, 2'd1, 1'b0, 64'h120,    64'h400080, 64'h1000, 3'b111, 1'b0, 5'd0,  64'h22,     64'h400000, 2'd1, 1'b1},
        '{1'b0, 2'd1, 1'b1, 64'h100,    64'h80,     64'h1000, 3'b111, 1'b0, 5'd0,  64'h20,     64'h80,     2'd1, 1'b1},
        '{1'b0, 2'd1, 1'b0, 64'h400120, 64'h0,      64'h1002, 3'b001, 1'b1, 5'd0,  64'h400120, 64'h0,      2'd1, 1'b0},
        '{1'b0, 2'd1, 1'b0, 64'h20,     64'h0,      64'h1002, 3'b101, 1'b0, 5'd0,  64'h22,     64'h0,      2'd0, 1'b0},
        '{1'b0, 2'd0, 1'b0, 64'h120,    64'h0,      64'h1002, 3'b001, 1'b1, 5'd2,  64'h120,    64'h0,      2'd0, 1'b0},
        '{1'b1, 2'd3, 1'b0, 64'h1880,   64'h0,      64'h2000, 3'b100, 1'b0, 5'd0,  64'h88,     64'h0,      2'd3, 1'b0},
        '{1'b1, 2'd3, 1'b0, 64'h800,    64'h0,      64'h2000, 3'b100, 1'b1, 5'd2,  64'h800,    64'h0,      2'd3, 1'b0},
        '{1'b1, 2'd3, 1'b0, 64'h8000000808, 64'h5,  64'h2000, 3'b111, 1'b0, 5'd0,  64'h80,     64'h5,      2'd1, 1'b1},
        '{1'b1, 2'd3, 1'b0, 64'h8000000808, 64'h5,  64'h2000, 3'b101, 1'b0, 5'd0,  64'h80,     64'h5,      2'd1, 1'b0},
        '{1'b1, 2'd1, 1'b0, 64'h1880,   64'h0,      64'h2000, 3'b101, 1'b1, 5'd2,  64'h1880,   64'h0,      2'd1, 1'b0},
        '{1'b1, 2'd3, 1'b0, 64'h800,    64'h0,      64'h2001, 3'b000, 1'b1, 5'd0,  64'h800,    64'h0,      2'd3, 1'b0}
    };

    function automatic string vec_tag(int i);
        case (i)
            0:  return "R5";
            1:  return "R3";
            2:  return "R1";
            3:  return "R3";
            4:  return "R4";
            5:  return "R6";
            6:  return "R6";
            7:  return "R11";
            8:  return "R2";
            9:  return "R11";
            10: return "R8";
            11: return "R8";
            12: return "R10";
            13: return "R10";
            14: return "R7";
            default: return "R11";
        endcase
    endfunction

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_is_mret = 1'b0;
    logic [1:0]  cur_priv = 2'd0;
    logic        cur_virt = 1'b0;
    logic [63:0] mstatus = '0;
    logic [63:0] hstatus = '0;
    logic [63:0] sepc = '0;
    logic [63:0] mepc = '0;
    logic        has_c = 1'b0;
    logic        has_h = 1'b0;
    logic        has_pmp = 1'b0;

    logic        done, exc_valid, virt_out;
    logic [4:0]  exc_cause;
    logic [63:0] ms_out, hs_out, pc_out;
    logic [1:0]  priv_out;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    trap_return_unit #(.PC_W(64)) dut_i (
        .clk              (clk),
        .rst_n            (rst_n),
        .req_valid_i      (req_valid),
        .req_is_mret_i    (req_is_mret),
        .cur_priv_i       (cur_priv),
        .cur_virt_i       (cur_virt),
        .mstatus_i        (mstatus),
        .hstatus_i        (hstatus),
        .sepc_i           (sepc),
        .mepc_i           (mepc),
        .has_compressed_i (has_c),
        .has_hyper_i      (has_h),
        .has_pmp_i        (has_pmp),
        .done_o           (done),
        .exc_valid_o      (exc_valid),
        .exc_cause_o      (exc_cause),
        .mstatus_o        (ms_out),
        .hstatus_o        (hs_out),
        .priv_o           (priv_out),
        .virt_o           (virt_out),
        .target_pc_o      (pc_out)
    );

    task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic apply(vec_t v);
        req_is_mret = v.mret;
        cur_priv    = v.pr;
        cur_virt    = v.vi;
        mstatus     = v.ms;
        hstatus     = v.hs;
        sepc        = v.mret ? ~v.ep : v.ep;
        mepc        = v.mret ? v.ep : ~v.ep;
        {has_c, has_h, has_pmp} = v.cfg;
    endtask

    task automatic check_vec(vec_t v, string tag);
        check(tag, "done",   {63'd0, done},      64'd1);
        check(tag, "exc",    {63'd0, exc_valid}, {63'd0, v.x_exc});
        if (v.x_exc) check(tag, "cause", {59'd0, exc_cause}, {59'd0, v.x_cause});
        check(tag, "mstatus", ms_out, v.x_ms);
        check(tag, "hstatus", hs_out, v.x_hs);
        check(tag, "priv",   {62'd0, priv_out}, {62'd0, v.x_pr});
        check(tag, "virt",   {63'd0, virt_out}, {63'd0, v.x_vi});
        check("R12", "target_pc", pc_out, v.ep);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R13 reset state
        check("R13", "reset done", {63'd0, done}, 64'd0);
        check("R13", "reset exc", {63'd0, exc_valid}, 64'd0);
        check("R13", "reset priv", {62'd0, priv_out}, 64'd3);
        check("R13", "reset virt", {63'd0, virt_out}, 64'd0);
        check("R13", "reset mstatus", ms_out, 64'd0);
        check("R13", "reset hstatus", hs_out, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i]);
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            check_vec(VECS[i], vec_tag(i));
            @(negedge clk);
            check("R13", "done pulse ends", {63'd0, done}, 64'd0);
        end

        // R13 outputs hold while idle even when inputs change
        apply(VECS[0]);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        mstatus  = 64'hFFFF;
        cur_priv = 2'd0;
        repeat (3) @(negedge clk);
        check("R13", "idle mstatus hold", ms_out, 64'h22);
        check("R13", "idle priv hold", {62'd0, priv_out}, 64'd1);
        check("R13", "idle done low", {63'd0, done}, 64'd0);

        // R13 back-to-back requests each produce their own result
        apply(VECS[0]);
        req_valid = 1'b1;
        @(negedge clk);
        check("R13", "b2b first exc", {63'd0, exc_valid}, 64'd0);
        check("R13", "b2b first ms", ms_out, 64'h22);
        apply(VECS[2]);
        @(negedge clk);
        req_valid = 1'b0;
        check("R1", "b2b second done", {63'd0, done}, 64'd1);
        check("R1", "b2b second exc", {63'd0, exc_valid}, 64'd1);
        check("R1", "b2b second cause", {59'd0, exc_cause}, 64'd2);
        @(negedge clk);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL R13 watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule